// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block takes a bank of peripheral interrupt request lines and steers each of them onto one of seven general-purpose core interrupt inputs, levels 7 through 13. A small 4-bit assignment code per source selects its target level. Each core input is driven high when at least one source routed to it is both asserted and enabled. The core input vector is registered, so a source edge appears at the core one clock later.

Software reaches the router through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational. The port exposes three assignment words holding eight codes each, a per-source enable mask and a read-only view of the raw source lines. Out of reset the assignment codes hold a fixed default map that spreads the 24 sources unevenly over the seven levels. All sources start disabled.

Top module: `irq_level_router`

## Requirements
- R1: After reset, assignment words 0, 1 and 2 read back 0x10000000, 0x33322221 and 0x66655444. This is the default map. Sources 0-6 go to code 0, sources 7-8 to code 1, sources 9-12 to code 2, sources 13-15 to code 3, sources 16-18 to code 4, sources 19-20 to code 5 and sources 21-23 to code 6.
- R2: After reset, the enable word (address 3) reads 0 and `core_irq` is 0 whatever the source lines do.
- R3: Bit i of `core_irq` (core level 7+i) is 1 one clock after an edge at which some source s has `src_irq[s]`=1, enable bit s = 1 and assignment code i. Otherwise the bit is 0.
- R4: The assignment code for source s sits in word s/8, bits [4*(s%8)+3 : 4*(s%8)]. Its value is the target level minus 7. A code of 7 to 15 removes the source from every output.
- R5: A write to an assignment word at clock edge k is readable immediately after edge k. It changes the routing seen in `core_irq` from edge k+1 onward. At edge k itself the output still reflects the old routing.
- R6: The enable word (address 3) holds bit s for source s. It reads back as written, with bits 31:24 reading 0. A source with its enable bit at 0 contributes to no output.
- R7: The status word (address 4) reads the current raw `src_irq` in bits 23:0 in the same cycle, regardless of enables. Writes to address 4 change no register.
- R8: Addresses 5 to 7 read 0, and writes to them change no register.
- R9: Several enabled sources on one level OR together. A source affects only the level its code selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 24 | Raw peripheral interrupt lines, bit s = source s |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| core_irq | output | 7 | Registered core interrupt requests, bit i = level 7+i |

## Verification
The bench targets the timing of a reassignment. It checks the output one edge after the write, where the old routing must still show, and again on the next edge. A design that routed straight from the write data would show the new level too early. A design with an extra stage would show it too late. It also loads out-of-range codes 7 and 15, which a truncating decoder would alias onto a real level. It checks that writes to the status and unused addresses leave the enable and assignment words intact, and that masked sources stay silent even while the status word shows them high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Lowest core level reachable by the router; codes are offsets from it.
    localparam int LVL_BASE = 7;

    // Code used for sources outside the default population: never routed.
    localparam int CODE_OFF = 15;

    // Default target code of source s (level minus LVL_BASE).
    function automatic int default_code(int s);
        if (s < 7)  return 0;
        if (s < 9)  return 1;
        if (s < 13) return 2;
        if (s < 16) return 3;
        if (s < 19) return 4;
        if (s < 21) return 5;
        if (s < 24) return 6;
        return CODE_OFF;
    endfunction

endpackage

// File: rtl/irq_router_cfg.sv
module irq_router_cfg #(
    parameter int NUM_SRC = 24,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NUM_SRC*FIELD_W-1:0] fields_o,
    output logic [NUM_SRC-1:0]         en_o
);
    localparam int FPR     = DATA_W / FIELD_W;
    localparam int NUM_ASG = (NUM_SRC + FPR - 1) / FPR;
    localparam int EN_ADDR = NUM_ASG;

    typedef struct packed {
        logic [NUM_SRC*FIELD_W-1:0] fields;
        logic [NUM_SRC-1:0]         en;
    } cfg_t;

    function automatic logic [NUM_SRC*FIELD_W-1:0] default_map();
        logic [NUM_SRC*FIELD_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            m[s*FIELD_W +: FIELD_W] = FIELD_W'(irq_router_pkg::default_code(s));
        end
        return m;
    endfunction

    localparam cfg_t CFG_RST = '{fields: default_map(), en: '0};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            for (int r = 0; r < NUM_ASG; r++) begin
                for (int f = 0; f < FPR; f++) begin
                    if (addr == ADDR_W'(r) && (r * FPR + f) < NUM_SRC) begin
                        cfg_d.fields[(r*FPR+f)*FIELD_W +: FIELD_W] =
                            wdata[f*FIELD_W +: FIELD_W];
                    end
                end
            end
            if (addr == ADDR_W'(EN_ADDR)) begin
                cfg_d.en = wdata[NUM_SRC-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fields_o = cfg_q.fields;
    assign en_o     = cfg_q.en;

endmodule

// File: rtl/irq_router_xbar.sv
module irq_router_xbar #(
    parameter int NUM_SRC = 24,
    parameter int NUM_LVL = 7,
    parameter int FIELD_W = 4
) (
    input  logic [NUM_SRC-1:0]         src,
    input  logic [NUM_SRC-1:0]         en,
    input  logic [NUM_SRC*FIELD_W-1:0] fields,
    output logic [NUM_LVL-1:0]         req
);
    // One OR plane per core level; a code with no matching level drops out.
    for (genvar lvl = 0; lvl < NUM_LVL; lvl++) begin : g_lvl
        logic [NUM_SRC-1:0] hit;
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign hit[s] = src[s] & en[s] &
                            (fields[s*FIELD_W +: FIELD_W] == FIELD_W'(lvl));
        end
        assign req[lvl] = |hit;
    end

endmodule

// File: rtl/irq_router_rdmux.sv
module irq_router_rdmux #(
    parameter int NUM_SRC = 24,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [NUM_SRC*FIELD_W-1:0] fields,
    input  logic [NUM_SRC-1:0]         en,
    input  logic [NUM_SRC-1:0]         src,
    output logic [DATA_W-1:0]          rdata
);
    localparam int FPR     = DATA_W / FIELD_W;
    localparam int NUM_ASG = (NUM_SRC + FPR - 1) / FPR;
    localparam int EN_ADDR = NUM_ASG;
    localparam int ST_ADDR = NUM_ASG + 1;

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_ASG; r++) begin
            for (int f = 0; f < FPR; f++) begin
                if (addr == ADDR_W'(r) && (r * FPR + f) < NUM_SRC) begin
                    rdata[f*FIELD_W +: FIELD_W] = fields[(r*FPR+f)*FIELD_W +: FIELD_W];
                end
            end
        end
        if (addr == ADDR_W'(EN_ADDR)) begin
            rdata[NUM_SRC-1:0] = en;
        end
        if (addr == ADDR_W'(ST_ADDR)) begin
            rdata[NUM_SRC-1:0] = src;
        end
    end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router #(
    parameter int NUM_SRC = 24,
    parameter int NUM_LVL = 7,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    output logic [NUM_LVL-1:0] core_irq
);
    typedef struct packed {
        logic [NUM_LVL-1:0] lvl;
    } out_t;

    logic [NUM_SRC*FIELD_W-1:0] fields;
    logic [NUM_SRC-1:0]         en;
    logic [NUM_LVL-1:0]         req;
    out_t                       out_d, out_q;

    irq_router_cfg #(
        .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .fields_o(fields), .en_o(en)
    );

    irq_router_xbar #(
        .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W)
    ) u_xbar (
        .src(src_irq), .en(en), .fields(fields), .req(req)
    );

    irq_router_rdmux #(
        .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_rdmux (
        .addr(cfg_addr), .fields(fields), .en(en), .src(src_irq), .rdata(cfg_rdata)
    );

    always_comb begin
        out_d     = out_q;
        out_d.lvl = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign core_irq = out_q.lvl;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 24,
    parameter int NUM_LVL = 7,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_irq,
    input logic               cfg_wr,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic [DATA_W-1:0]  cfg_wdata,
    input logic [DATA_W-1:0]  cfg_rdata,
    input logic [NUM_LVL-1:0] core_irq
);
    localparam int FPR     = DATA_W / FIELD_W;
    localparam int NUM_ASG = (NUM_SRC + FPR - 1) / FPR;
    localparam int EN_ADDR = NUM_ASG;
    localparam int ST_ADDR = NUM_ASG + 1;

    // Output is quiet in the cycle after any reset cycle.
    p_reset_quiet_r2: assert property (@(posedge clk)
        !rst_n |=> core_irq == '0);

    // With no source asserted, no level is raised on the next edge.
    p_silent_sources_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_irq == '0) |=> core_irq == '0);

    // Assignment word 0 reads back what was written to it.
    p_assign_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == '0) |=>
            (cfg_addr != '0 || cfg_rdata == $past(cfg_wdata)));

    // Clearing every enable bit silences the output two edges later.
    p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == ADDR_W'(EN_ADDR) && cfg_wdata[NUM_SRC-1:0] == '0)
            |=> ##1 core_irq == '0);

    // The status word mirrors the raw source lines.
    p_status_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(ST_ADDR)) |-> cfg_rdata == DATA_W'(src_irq));

endmodule

bind irq_level_router irq_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .FIELD_W(FIELD_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .core_irq(core_irq)
);

// File: tb/irq_level_router_bench.sv
module irq_level_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_irq = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [6:0]  core_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_level_router u_irq_level_router (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .core_irq(core_irq)
    );

    // {enable, sources, expected core_irq} under the default map
    localparam int NV = 13;
    localparam logic [54:0] VEC [NV] = '{
        {24'hFFFFFF, 24'h000001, 7'h01},   // R3 level 7
        {24'hFFFFFF, 24'h000080, 7'h02},   // R3 level 8
        {24'hFFFFFF, 24'h001E00, 7'h04},   // R9 four on level 9
        {24'hFFFFFF, 24'h00E000, 7'h08},
        {24'hFFFFFF, 24'h070000, 7'h10},
        {24'hFFFFFF, 24'h180000, 7'h20},
        {24'hFFFFFF, 24'hE00000, 7'h40},
        {24'h000000, 24'hFFFFFF, 7'h00},   // R6 all masked
        {24'h800001, 24'hFFFFFF, 7'h41},   // R6 partial mask
        {24'hFFFFFF, 24'h000100, 7'h02},
        {24'h00FF00, 24'h0000FF, 7'h00},   // R6 masked sources
        {24'hFFFFFF, 24'hFFFFFF, 7'h7F},   // R9 all levels
        {24'h000040, 24'h000041, 7'h01}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        src_irq = 24'hFFFFFF;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 core quiet after reset", 32'(core_irq), 32'h0);
        rd_reg(3'd0, rd); check("R1 word0", rd, 32'h10000000);
        rd_reg(3'd1, rd); check("R1 word1", rd, 32'h33322221);
        rd_reg(3'd2, rd); check("R1 word2", rd, 32'h66655444);
        rd_reg(3'd3, rd); check("R2 enable reset", rd, 32'h0);
        rd_reg(3'd5, rd); check("R8 addr5 read", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr_reg(3'd3, {8'h00, VEC[i][54:31]});
            src_irq = VEC[i][30:7];
            @(negedge clk);
            check("R3 R6 R9 vector", 32'(core_irq), 32'(VEC[i][6:0]));
        end

        // R6 enable readback
        wr_reg(3'd3, 32'hFF5A5A5A);
        rd_reg(3'd3, rd); check("R6 enable readback", rd, 32'h005A5A5A);

        // R5 reassignment timing
        wr_reg(3'd3, 32'h00FFFFFF);
        src_irq = 24'h000001;
        @(negedge clk);
        check("R5 before write", 32'(core_irq), 32'h01);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h10000006;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R5 old routing at write edge", 32'(core_irq), 32'h01);
        rd_reg(3'd0, rd); check("R5 readback", rd, 32'h10000006);
        @(negedge clk);
        check("R5 new routing", 32'(core_irq), 32'h40);

        // R4 out-of-range codes
        wr_reg(3'd0, 32'h10000007);
        @(negedge clk);
        check("R4 code 7 unrouted", 32'(core_irq), 32'h0);
        wr_reg(3'd0, 32'h1000000F);
        @(negedge clk);
        check("R4 code 15 unrouted", 32'(core_irq), 32'h0);
        wr_reg(3'd0, 32'h10000003);
        @(negedge clk);
        check("R4 code 3 level 10", 32'(core_irq), 32'h08);

        // R7 status raw regardless of enables, writes ignored
        wr_reg(3'd3, 32'h0);
        src_irq = 24'hA5A5A5;
        rd_reg(3'd4, rd); check("R7 status raw", rd, 32'h00A5A5A5);
        @(negedge clk);
        check("R7 masked output quiet", 32'(core_irq), 32'h0);
        wr_reg(3'd4, 32'hFFFFFFFF);
        rd_reg(3'd3, rd); check("R7 enable unchanged", rd, 32'h0);
        rd_reg(3'd0, rd); check("R7 word0 unchanged", rd, 32'h10000003);

        // R8 unused addresses
        wr_reg(3'd5, 32'hFFFFFFFF);
        wr_reg(3'd7, 32'hFFFFFFFF);
        rd_reg(3'd5, rd); check("R8 addr5 read", rd, 32'h0);
        rd_reg(3'd7, rd); check("R8 addr7 read", rd, 32'h0);
        rd_reg(3'd1, rd); check("R8 word1 unchanged", rd, 32'h33322221);
        rd_reg(3'd3, rd); check("R8 enable unchanged", rd, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule